// File: doc/BRIEF.md
# Effective Address Generator

This block turns an addressing mode, a program counter and two 8-bit index registers into the 16-bit address of an instruction's operand. The program counter given to it points at the first operand byte that follows the opcode. A short sequencer fetches the operand bytes it needs, and in the pointer modes the pointer bytes as well. It uses a byte-wide memory port and makes at most one read per clock. When the address is ready it raises `done` for one cycle.

The memory port is combinational. The block drives `memAddr` and raises `memRd`, and the byte on `memData` is taken at the rising clock edge that ends that cycle. Mode, program counter and index values are captured in the cycle that starts the sequence. After that the caller may change them freely. The result stays on `effAddr` until the next start.

Mode codes on `mode`: 0 immediate, 1 zero page, 2 zero page + X, 3 zero page + Y, 4 absolute, 5 absolute + X, 6 absolute + Y, 7 pre-indexed indirect (X), 8 post-indexed indirect (Y), 9 indirect jump target. Code 10 means "no operand", and codes 11 to 15 are invalid.

Top module: `ea_unit`

## Requirements
- R1: `start` is accepted only while the block is idle. Mode, pc, X and Y are captured in that cycle, and later changes to them have no effect on the result. A `start` pulse while a sequence is running is ignored.
- R2: Mode 0 (immediate) gives `effAddr` = pc with no memory read, and `done` comes 1 cycle after the start cycle.
- R3: Mode 1 (zero page) reads one byte at pc and gives `effAddr` = {0x00, byte}.
- R4: Modes 2 and 3 add X or Y to the byte read at pc modulo 256, so the high byte of `effAddr` is always 0x00.
- R5: Mode 4 (absolute) reads the low byte at pc and then the high byte at pc+1.
- R6: Modes 5 and 6 add the zero-extended X (mode 5) or Y (mode 6) to the 16-bit absolute base, wrapping modulo 65536.
- R7: In mode 7, pointer p = (byte at pc + X) mod 256. The address is low byte at {0x00,p} and high byte at {0x00,(p+1) mod 256}.
- R8: In mode 8, the base low byte is read at {0x00,b} and the high byte at {0x00,(b+1) mod 256}, where b is the byte at pc. Y is then added with 16-bit wrap.
- R9: In mode 9, a 16-bit pointer is read from pc and pc+1, and the target low byte is read at that pointer. The target high byte is read at the pointer's low byte + 1 inside the same page. A pointer ending in 0xFF therefore takes its high byte from offset 0x00 of that page.
- R10: Modes 10 to 15 make no memory read. They raise `err` together with `done` one cycle after start, and `effAddr` reads 0x0000.
- R11: `done` is high for exactly one cycle, and `memRd` is never high in the same cycle as `done`. `effAddr` holds its value from `done` until the next accepted start.
- R12: The number of cycles from the start cycle to `done` equals the number of memory reads plus one. That is 1 read for modes 1 to 3, 2 for modes 4 to 6, 3 for modes 7 and 8, and 4 for mode 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sequence (taken while idle) |
| mode | input | 4 | Addressing mode code |
| pc | input | 16 | Address of the first operand byte |
| xIdx | input | 8 | X index value |
| yIdx | input | 8 | Y index value |
| memAddr | output | 16 | Memory read address |
| memRd | output | 1 | Memory read strobe |
| memData | input | 8 | Read data, valid in the cycle `memRd` is high |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Mode has no operand address (with `done`) |
| effAddr | output | 16 | Effective operand address |

## Verification
The bench goes after the wrap points. It uses index sums that cross 0xFF in the zero-page modes, a zero-page pointer at 0xFF in both indirect modes, an absolute base near 0xFFFF, and an indirect-jump pointer ending in 0xFF. A design that carried into the high byte would leave page zero or fetch the jump target's high byte from the next page. Absolute + Y is driven with X and Y different, so a design that indexed with X shows the wrong address. Inputs are scrambled after start and a second start is pulsed mid-sequence: a design that sampled late or restarted would return an address built from the wrong operands or finish at the wrong cycle.

// File: rtl/eag_pkg.sv
`timescale 1ns/1ps
package eag_pkg;

  localparam logic [3:0] MODE_IMM  = 4'd0;
  localparam logic [3:0] MODE_ZP   = 4'd1;
  localparam logic [3:0] MODE_ZPX  = 4'd2;
  localparam logic [3:0] MODE_ZPY  = 4'd3;
  localparam logic [3:0] MODE_ABS  = 4'd4;
  localparam logic [3:0] MODE_ABSX = 4'd5;
  localparam logic [3:0] MODE_ABSY = 4'd6;
  localparam logic [3:0] MODE_INDX = 4'd7;
  localparam logic [3:0] MODE_INDY = 4'd8;
  localparam logic [3:0] MODE_JIND = 4'd9;

  // which address the datapath puts on the memory port
  typedef enum logic [1:0] {
    SEL_PC   = 2'd0,
    SEL_PC1  = 2'd1,
    SEL_PTR0 = 2'd2,
    SEL_PTR1 = 2'd3
  } addrSel_e;

  typedef struct packed {
    logic     capture;
    logic     rd;
    addrSel_e sel;
    logic     ldOp0;
    logic     ldOp1;
    logic     ldPtr0;
    logic     ldPtr1;
  } strobe_t;

  function automatic logic modeValid(input logic [3:0] m);
    return m <= MODE_JIND;
  endfunction

  function automatic logic modeZpFamily(input logic [3:0] m);
    return (m == MODE_ZP) || (m == MODE_ZPX) || (m == MODE_ZPY);
  endfunction

  function automatic logic modeZpPointer(input logic [3:0] m);
    return (m == MODE_INDX) || (m == MODE_INDY);
  endfunction

endpackage

// File: rtl/eag_ctrl.sv
`timescale 1ns/1ps
module eag_ctrl
  import eag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] modeIn,
  input  logic [3:0] modeQ,
  output strobe_t    stb,
  output logic       done,
  output logic       err
);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_OP0  = 3'd1,
    S_OP1  = 3'd2,
    S_PLO  = 3'd3,
    S_PHI  = 3'd4,
    S_DONE = 3'd5
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb       = '0;
    stb.sel   = SEL_PC;
    stateNext = state;
    done      = 1'b0;
    err       = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          stb.capture = 1'b1;
          if (modeIn == MODE_IMM || !modeValid(modeIn)) stateNext = S_DONE;
          else                                          stateNext = S_OP0;
        end
      end
      S_OP0: begin
        stb.rd    = 1'b1;
        stb.sel   = SEL_PC;
        stb.ldOp0 = 1'b1;
        if (modeZpFamily(modeQ))       stateNext = S_DONE;
        else if (modeZpPointer(modeQ)) stateNext = S_PLO;
        else                           stateNext = S_OP1;
      end
      S_OP1: begin
        stb.rd    = 1'b1;
        stb.sel   = SEL_PC1;
        stb.ldOp1 = 1'b1;
        stateNext = (modeQ == MODE_JIND) ? S_PLO : S_DONE;
      end
      S_PLO: begin
        stb.rd     = 1'b1;
        stb.sel    = SEL_PTR0;
        stb.ldPtr0 = 1'b1;
        stateNext  = S_PHI;
      end
      S_PHI: begin
        stb.rd     = 1'b1;
        stb.sel    = SEL_PTR1;
        stb.ldPtr1 = 1'b1;
        stateNext  = S_DONE;
      end
      S_DONE: begin
        done      = 1'b1;
        err       = !modeValid(modeQ);
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/eag_dp.sv
`timescale 1ns/1ps
module eag_dp
  import eag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [3:0]            modeIn,
  input  logic [2*DATA_W-1:0]   pcIn,
  input  logic [DATA_W-1:0]     xIn,
  input  logic [DATA_W-1:0]     yIn,
  input  logic [DATA_W-1:0]     memData,
  output logic [2*DATA_W-1:0]   memAddr,
  output logic [2*DATA_W-1:0]   effAddr,
  output logic [3:0]            modeQ
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] ZERO_PAGE = '0;

  logic [ADDR_W-1:0] pcQ;
  logic [DATA_W-1:0] xQ, yQ, op0, op1, ptr0, ptr1;
  logic [DATA_W-1:0] zpBase, zpNext, jumpLoNext;
  logic [ADDR_W-1:0] absBase, ptrWord, xWide, yWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      pcQ   <= '0;
      xQ    <= '0;
      yQ    <= '0;
      op0   <= '0;
      op1   <= '0;
      ptr0  <= '0;
      ptr1  <= '0;
    end else begin
      if (stb.capture) begin
        modeQ <= modeIn;
        pcQ   <= pcIn;
        xQ    <= xIn;
        yQ    <= yIn;
      end
      if (stb.ldOp0)  op0  <= memData;
      if (stb.ldOp1)  op1  <= memData;
      if (stb.ldPtr0) ptr0 <= memData;
      if (stb.ldPtr1) ptr1 <= memData;
    end
  end

  // zero-page pointer arithmetic stays inside DATA_W bits
  always_comb begin
    zpBase     = op0 + ((modeQ == MODE_INDX) ? xQ : ZERO_PAGE);
    zpNext     = zpBase + 1'b1;
    jumpLoNext = op0 + 1'b1;
    absBase    = {op1, op0};
    ptrWord    = {ptr1, ptr0};
    xWide      = {ZERO_PAGE, xQ};
    yWide      = {ZERO_PAGE, yQ};
  end

  always_comb begin
    unique case (stb.sel)
      SEL_PC:   memAddr = pcQ;
      SEL_PC1:  memAddr = pcQ + 1'b1;
      SEL_PTR0: memAddr = (modeQ == MODE_JIND) ? absBase : {ZERO_PAGE, zpBase};
      SEL_PTR1: memAddr = (modeQ == MODE_JIND) ? {op1, jumpLoNext} : {ZERO_PAGE, zpNext};
      default:  memAddr = pcQ;
    endcase
  end

  always_comb begin
    logic [DATA_W-1:0] zpSum;
    zpSum = op0 + ((modeQ == MODE_ZPY) ? yQ : xQ);
    unique case (modeQ)
      MODE_IMM:             effAddr = pcQ;
      MODE_ZP:              effAddr = {ZERO_PAGE, op0};
      MODE_ZPX, MODE_ZPY:   effAddr = {ZERO_PAGE, zpSum};
      MODE_ABS:             effAddr = absBase;
      MODE_ABSX:            effAddr = absBase + xWide;
      MODE_ABSY:            effAddr = absBase + yWide;
      MODE_INDX, MODE_JIND: effAddr = ptrWord;
      MODE_INDY:            effAddr = ptrWord + yWide;
      default:              effAddr = '0;
    endcase
  end

endmodule

// File: rtl/ea_unit.sv
`timescale 1ns/1ps
module ea_unit
  import eag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [3:0]          mode,
  input  logic [2*DATA_W-1:0] pc,
  input  logic [DATA_W-1:0]   xIdx,
  input  logic [DATA_W-1:0]   yIdx,
  output logic [2*DATA_W-1:0] memAddr,
  output logic                memRd,
  input  logic [DATA_W-1:0]   memData,
  output logic                done,
  output logic                err,
  output logic [2*DATA_W-1:0] effAddr
);

  strobe_t    stb;
  logic [3:0] curMode;

  eag_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .modeIn (mode),
    .modeQ  (curMode),
    .stb    (stb),
    .done   (done),
    .err    (err)
  );

  eag_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .modeIn  (mode),
    .pcIn    (pc),
    .xIn     (xIdx),
    .yIn     (yIdx),
    .memData (memData),
    .memAddr (memAddr),
    .effAddr (effAddr),
    .modeQ   (curMode)
  );

  assign memRd = stb.rd;

endmodule

// File: rtl/ea_unit_chk.sv
`timescale 1ns/1ps
module ea_unit_chk
  import eag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                memRd,
  input logic                done,
  input logic                err,
  input logic [2*DATA_W-1:0] effAddr,
  input logic [3:0]          curMode
);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  no_read_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memRd);

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> $stable(effAddr));

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (done && effAddr == '0));

  // R3 R4
  zp_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && modeZpFamily(curMode)) |-> (effAddr[2*DATA_W-1:DATA_W] == '0));

endmodule

bind ea_unit ea_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .memRd   (memRd),
  .done    (done),
  .err     (err),
  .effAddr (effAddr),
  .curMode (curMode)
);

// File: tb/sim_ea_unit.sv
`timescale 1ns/1ps
module sim_ea_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic [15:0] pc = 16'd0;
  logic [7:0]  xIdx = 8'd0;
  logic [7:0]  yIdx = 8'd0;
  logic [15:0] memAddr;
  logic        memRd;
  logic [7:0]  memData;
  logic        done;
  logic        err;
  logic [15:0] effAddr;
  logic [7:0]  salt = 8'd0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ea_unit u0 (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .pc(pc),
    .xIdx(xIdx), .yIdx(yIdx), .memAddr(memAddr), .memRd(memRd),
    .memData(memData), .done(done), .err(err), .effAddr(effAddr)
  );

  // bench memory: a computed byte pattern, shifted by salt
  function automatic logic [7:0] memByte(input logic [15:0] a, input logic [7:0] s);
    logic [7:0] r;
    r = a[7:0] * 8'd37 + a[15:8] * 8'd11 + s;
    return r;
  endfunction

  assign memData = memByte(memAddr, salt);

  function automatic void expect_ea(input logic [3:0] m, input logic [15:0] p,
                                    input logic [7:0] xv, input logic [7:0] yv,
                                    input logic [7:0] s, output logic [15:0] ea,
                                    output int lat, output bit er);
    logic [7:0] b0, b1, z, z1, lo, hi;
    logic [15:0] t;
    b0 = memByte(p, s);
    b1 = memByte(p + 16'd1, s);
    er = 1'b0;
    case (m)
      4'd0: begin ea = p; lat = 1; end
      4'd1: begin ea = {8'h00, b0}; lat = 2; end
      4'd2: begin z = b0 + xv; ea = {8'h00, z}; lat = 2; end
      4'd3: begin z = b0 + yv; ea = {8'h00, z}; lat = 2; end
      4'd4: begin ea = {b1, b0}; lat = 3; end
      4'd5: begin ea = {b1, b0} + {8'h00, xv}; lat = 3; end
      4'd6: begin ea = {b1, b0} + {8'h00, yv}; lat = 3; end
      4'd7: begin
        z = b0 + xv; z1 = z + 8'd1;
        lo = memByte({8'h00, z}, s); hi = memByte({8'h00, z1}, s);
        ea = {hi, lo}; lat = 4;
      end
      4'd8: begin
        z1 = b0 + 8'd1;
        lo = memByte({8'h00, b0}, s); hi = memByte({8'h00, z1}, s);
        ea = {hi, lo} + {8'h00, yv}; lat = 4;
      end
      4'd9: begin
        t = {b1, b0};
        lo = memByte(t, s);
        if (b0 == 8'hff) hi = memByte({b1, 8'h00}, s);
        else             hi = memByte(t + 16'd1, s);
        ea = {hi, lo}; lat = 5;
      end
      default: begin ea = 16'h0000; lat = 1; er = 1'b1; end
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one full sequence; probe pulses start again while busy
  task automatic run_op(input logic [3:0] m, input logic [15:0] p, input logic [7:0] xv,
                        input logic [7:0] yv, input logic [7:0] s, input bit probe,
                        input string req);
    logic [15:0] expEa, held;
    int expLat, reads, lat;
    bit expErr, got;
    expect_ea(m, p, xv, yv, s, expEa, expLat, expErr);
    @(negedge clk);
    salt = s; mode = m; pc = p; xIdx = xv; yIdx = yv; start = 1'b1;
    reads = 0; got = 1'b0; lat = 0; held = 16'h0;
    for (int c = 1; c <= 8 && !got; c++) begin
      @(negedge clk);
      if (done) begin
        got = 1'b1; lat = c; held = effAddr;
        check(effAddr == expEa, req, "effAddr", effAddr, expEa);
        check(err == expErr, req, "err", err, expErr);
        // R12 latency and read count
        check(lat == expLat, "R12", "latency", lat, expLat);
        check(reads == expLat - 1, "R12", "reads", reads, expLat - 1);
      end else if (memRd) reads++;
      if (c == 1) begin
        // R1: inputs changed after the start cycle
        start = 1'b0;
        mode = 4'($urandom); pc = 16'($urandom);
        xIdx = 8'($urandom); yIdx = 8'($urandom);
      end
      if (probe && c == 2) start = 1'b1;
      if (probe && c == 3) start = 1'b0;
    end
    if (!got) check(1'b0, req, "no done", 0, 1);
    @(negedge clk);
    // R11 one-cycle done, address held afterwards
    check(!done, "R11", "done width", done, 0);
    check(effAddr == held, "R11", "effAddr hold", effAddr, held);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s;
    logic [15:0] p;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(done == 1'b0 && memRd == 1'b0 && err == 1'b0, "R11", "reset outputs",
          {done, memRd, err}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed: one per mode
    run_op(4'd0, 16'h1234, 8'h10, 8'h20, 8'h00, 0, "R2");
    run_op(4'd1, 16'h0600, 8'h10, 8'h20, 8'h03, 0, "R3");
    run_op(4'd2, 16'h0601, 8'hff, 8'h01, 8'h40, 0, "R4");
    run_op(4'd3, 16'h0602, 8'h01, 8'hf0, 8'h70, 0, "R4");
    run_op(4'd4, 16'h8000, 8'h00, 8'h00, 8'h11, 0, "R5");
    run_op(4'd5, 16'h8010, 8'h33, 8'h99, 8'h22, 0, "R6");
    run_op(4'd6, 16'h8010, 8'h33, 8'h99, 8'h22, 0, "R6");
    run_op(4'd7, 16'h0700, 8'h05, 8'h00, 8'h5a, 0, "R7");
    run_op(4'd8, 16'h0700, 8'h00, 8'h44, 8'h5a, 0, "R8");
    run_op(4'd9, 16'h0900, 8'h00, 8'h00, 8'h13, 0, "R9");
    run_op(4'd10, 16'h0900, 8'h00, 8'h00, 8'h13, 0, "R10");
    run_op(4'd15, 16'h0900, 8'h00, 8'h00, 8'h13, 0, "R10");

    // R7: zero-page pointer lands on 0xFF
    p = 16'h0c35; s = 8'h21;
    run_op(4'd7, p, 8'hff - memByte(p, s), 8'h00, s, 0, "R7");
    // R8: operand byte 0xFF
    p = 16'h0d02; s = 8'hff - (p[7:0] * 8'd37 + p[15:8] * 8'd11);
    run_op(4'd8, p, 8'h00, 8'hc3, s, 0, "R8");
    // R9: jump pointer ending in 0xFF
    p = 16'h0e40; s = 8'hff - (p[7:0] * 8'd37 + p[15:8] * 8'd11);
    run_op(4'd9, p, 8'h00, 8'h00, s, 0, "R9");
    // R6: base high byte 0xFF, index wraps past 0xFFFF
    p = 16'h0f10; s = 8'hff - ((p[7:0] + 8'd1) * 8'd37 + p[15:8] * 8'd11);
    run_op(4'd5, p, 8'hff, 8'h00, s, 0, "R6");
    run_op(4'd6, p, 8'h00, 8'hff, s, 0, "R6");
    // R4: index sum crossing 0xFF
    run_op(4'd3, 16'h0123, 8'h00, 8'hff, 8'h77, 0, "R4");
    // R1: start pulsed while busy
    run_op(4'd7, 16'h0456, 8'h12, 8'h34, 8'h09, 1, "R1");
    run_op(4'd9, 16'h0789, 8'h12, 8'h34, 8'h0a, 1, "R1");

    // random
    for (int i = 0; i < 60; i++) begin
      run_op(4'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
             8'($urandom), 1'b0, "R1");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule